// File: doc/BRIEF.md
# Potentiometer Wiper Register and Non-Volatile Control

This block holds the register state behind the serial port of a 256-position digital potentiometer. A serial engine decodes host frames and hands the block single-cycle read and write strobes with a 5-bit register address and an 8-bit data byte. A write strobe is presented when the host ends a frame, which is when a write takes effect. The block drives the tap code for the resistor switch array, a control that opens the end-to-end resistor path, and the output-driver type bit that the serial engine uses for its data-out pin.

Storage is split into a volatile wiper code, a persistent power-up value, fourteen persistent general-purpose bytes, a reserved location and a volatile mode/status word. The persistent array is modelled as registers behind a write port that takes a parameterised number of clock cycles. The power-up value and the wiper share address 0, and a mode bit in the mode/status word decides which one a host access reaches. While a persistent write is running, a busy flag shuts out every access except reads of the mode/status word, so the host can poll for completion. A `pwr_good` input models the supply: while it is low, volatile state is held at its power-on values. When it rises, the stored power-up value is copied into the wiper.

Top module: `potwiper_ctrl`

## Requirements
- R1: When `rst_n` is low or `pwr_good` is low, the wiper code is 0x80, the mode/status word reads 0x40 (VOL=0, SHDN=1, SDO-type=0), `pot_open` is 0 and no persistent write is pending. `rst_n` also clears every persistent byte to 0x00.
- R2: On the first cycle with `pwr_good` high after it was low, the wiper is loaded from the stored power-up value, and strobes in that cycle are ignored. A persistent write cut short by `pwr_good` falling leaves the stored byte unchanged.
- R3: With VOL=1 (bit 7 of address 0x10), a write to address 0 changes only the volatile wiper. It starts no persistent write, and a read of address 0 returns the wiper code.
- R4: With VOL=0, a write to address 0 loads the wiper on that edge and starts a persistent write of the power-up value. WIP (bit 5 of address 0x10) reads 1 for exactly NV_CYCLES cycles, and the value is committed at the end.
- R5: With VOL=0, reading address 0 returns the stored power-up value and never changes the wiper code, even when the two differ.
- R6: Addresses 0x01 to 0x0E are persistent general-purpose bytes. A write to one of them runs the same timed write as R4 and reads back unchanged once WIP clears.
- R7: Address 0x10 reads as {VOL, SHDN, WIP, 0, 0, 0, SDO-type, 0}. A write to it sets bits 7, 6 and 1 at once, and the written WIP bit and the zero bits are ignored. `sdo_open_drain` follows bit 1.
- R8: While WIP=1, every write is dropped (a write of 0xFF to address 0x10 changes nothing). Every read returns 0x00, except a read of address 0x10.
- R9: While SHDN=0, `wiper_tap` is 0x00 and `pot_open` is 1, and the wiper register still accepts writes. When SHDN returns to 1, `wiper_tap` shows the wiper register again.
- R10: A write to reserved address 0x0F, or to any address above 0x10, changes no state and starts no persistent write. A read of any of these addresses returns 0x00.
- R11: `rd_data` takes its new value at the clock edge that ends a cycle with `rd_stb` high (one cycle of latency). It holds that value until the next accepted read, and is cleared while `pwr_good` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset, factory-blank state |
| pwr_good | input | 1 | Supply adequate; low holds volatile state at power-on values |
| wr_stb | input | 1 | One-cycle write strobe from the serial engine (frame end) |
| rd_stb | input | 1 | One-cycle read strobe from the serial engine |
| reg_addr | input | 5 | Register address for the strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| wiper_tap | output | 8 | Tap code driving the switch array, 0x00 nearest low end, 0xFF nearest high end |
| pot_open | output | 1 | High opens the end-to-end resistor path (shutdown) |
| sdo_open_drain | output | 1 | Data-out driver type: 1 open drain, 0 push-pull |

## Verification
The checker watches several properties on every cycle. It confirms the power-low hold values and the recall from the stored power-up value. It confirms that the busy window never runs past NV_CYCLES, that dropped writes during busy and plain reads leave the wiper register alone, and that the tap stays at zero throughout a shutdown. Other behaviour shows only in the bench's scenarios. These include address aliasing under both VOL settings, the field layout of the mode/status word, general-purpose readback, the reserved and out-of-range addresses, and a persistent write abandoned by a supply drop. The bench checks all of these against its cycle model of the register file.

// File: rtl/pot_pkg.sv
// Package: shared constants for the potentiometer register block.
// Assumes an 8-bit data path and a 5-bit register address space.
package pot_pkg;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 8;
    localparam int GP_COUNT    = 14;
    localparam int NV_DEPTH    = GP_COUNT + 1;
    localparam logic [ADDR_W-1:0] ADR_SHARED = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 5'h10;
    localparam int BIT_VOL  = 7;
    localparam int BIT_SHDN = 6;
    localparam int BIT_WIP  = 5;
    localparam int BIT_SDO  = 1;
    localparam logic [DATA_W-1:0] WIPER_POWERON = 8'h80;
    localparam logic [DATA_W-1:0] NV_BLANK      = 8'h00;

    typedef struct packed {
        logic vol;
        logic shdn;
        logic sdo_od;
    } mode_t;

    localparam mode_t MODE_POWERON = '{vol: 1'b0, shdn: 1'b1, sdo_od: 1'b0};
endpackage

// File: rtl/pot_nv_store.sv
// Persistent byte array behind a timed write port.
// A start pulse latches index and data. Busy then stays high for NV_CYCLES
// cycles, and the byte is committed on the last one. An abort (supply loss)
// drops the pending byte. Starts while busy are the caller's job to block.
module pot_nv_store #(
    parameter int DEPTH     = 15,
    parameter int DATA_W    = 8,
    parameter int NV_CYCLES = 1_000_000,
    parameter logic [DATA_W-1:0] BLANK = '0,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [DATA_W-1:0] start_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] word0,
    output logic              busy
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  pend_idx;
    logic [DATA_W-1:0] pend_data;
    logic [CNT_W-1:0]  remain;
    logic              commit;

    assign commit = busy && (remain == '0) && !abort;

    // Timer and pending-write latch for the self-timed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy      <= 1'b0;
            remain    <= '0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (start) begin
            busy      <= 1'b1;
            remain    <= CNT_W'(NV_CYCLES - 1);
            pend_idx  <= start_idx;
            pend_data <= start_data;
        end
    end

    // One storage word per location; each takes the pending byte on commit.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= BLANK;
            else if (commit && (pend_idx == IDX_W'(g)))
                mem[g] <= pend_data;
        end
    end

    // Asynchronous read port; out-of-range indices read blank.
    always_comb begin
        rd_word = BLANK;
        if (32'(rd_idx) < DEPTH) rd_word = mem[rd_idx];
    end

    assign word0 = mem[0];
endmodule

// File: rtl/pot_mode_reg.sv
// Volatile mode word: access-select, shutdown-release and driver-type bits.
// Returns to its power-on values on reset or while the supply is low.
module pot_mode_reg
    import pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_low,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode
);
    // Capture the writable fields; the status bit and zero bits are discarded.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_low)
            mode <= MODE_POWERON;
        else if (we) begin
            mode.vol    <= wdata[BIT_VOL];
            mode.shdn   <= wdata[BIT_SHDN];
            mode.sdo_od <= wdata[BIT_SDO];
        end
    end
endmodule

// File: rtl/pot_wiper.sv
// Volatile wiper register and tap driver.
// Priority: supply low forces mid-scale, then recall, then host load.
// In shutdown the tap is parked at the low end and the register is kept.
module pot_wiper #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] POWERON = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_low,
    input  logic              recall,
    input  logic [DATA_W-1:0] recall_val,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shdn_n,
    output logic [DATA_W-1:0] wiper_q,
    output logic [DATA_W-1:0] tap,
    output logic              open_path
);
    // Wiper register update with power-on, recall and host-write sources.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_low) wiper_q <= POWERON;
        else if (recall)       wiper_q <= recall_val;
        else if (load)         wiper_q <= load_val;
    end

    // Tap selection: low terminal while shut down.
    always_comb begin
        tap       = shdn_n ? wiper_q : '0;
        open_path = !shdn_n;
    end
endmodule

// File: rtl/potwiper_ctrl.sv
// Register bank and control for a 256-position digital potentiometer.
// Assumes single-cycle strobes from a serial engine, never read and write
// together, with a write strobe issued at frame end. pwr_good is synchronous.
module potwiper_ctrl
    import pot_pkg::*;
#(
    parameter int NV_CYCLES = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wiper_tap,
    output logic              pot_open,
    output logic              sdo_open_drain
);
    localparam int IDX_W = $clog2(NV_DEPTH);

    logic              pg_q;
    logic              ready;
    logic              recall;
    logic              busy_w;
    logic              wr_ok;
    logic              sel_shared, sel_gp, sel_mode;
    logic              nv_start;
    logic              wiper_load;
    logic              mode_we;
    mode_t             mode_w;
    logic [DATA_W-1:0] wiper_reg_w;
    logic [DATA_W-1:0] nv_rd;
    logic [DATA_W-1:0] nv_word0;
    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] rd_next;
    logic [IDX_W-1:0]  nv_idx;

    // Track the previous supply state to find the recall cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pwr_good;
    end

    // Address decode and write routing.
    always_comb begin
        ready      = pwr_good && pg_q;
        recall     = pwr_good && !pg_q;
        sel_shared = (reg_addr == ADR_SHARED);
        sel_gp     = (reg_addr >= ADDR_W'(1)) && (reg_addr <= ADDR_W'(GP_COUNT));
        sel_mode   = (reg_addr == ADR_MODE);
        wr_ok      = ready && wr_stb && !busy_w;
        wiper_load = wr_ok && sel_shared;
        nv_start   = wr_ok && ((sel_shared && !mode_w.vol) || sel_gp);
        mode_we    = wr_ok && sel_mode;
        nv_idx     = reg_addr[IDX_W-1:0];
    end

    pot_nv_store #(
        .DEPTH     (NV_DEPTH),
        .DATA_W    (DATA_W),
        .NV_CYCLES (NV_CYCLES),
        .BLANK     (NV_BLANK)
    ) u_nv (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (!pwr_good),
        .start      (nv_start),
        .start_idx  (nv_idx),
        .start_data (wr_data),
        .rd_idx     (nv_idx),
        .rd_word    (nv_rd),
        .word0      (nv_word0),
        .busy       (busy_w)
    );

    pot_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_low (!pwr_good),
        .we      (mode_we),
        .wdata   (wr_data),
        .mode    (mode_w)
    );

    pot_wiper #(
        .DATA_W  (DATA_W),
        .POWERON (WIPER_POWERON)
    ) u_wiper (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_low    (!pwr_good),
        .recall     (recall),
        .recall_val (nv_word0),
        .load       (wiper_load),
        .load_val   (wr_data),
        .shdn_n     (mode_w.shdn),
        .wiper_q    (wiper_reg_w),
        .tap        (wiper_tap),
        .open_path  (pot_open)
    );

    // Assemble the mode/status word as seen by the host.
    always_comb begin
        mode_word           = '0;
        mode_word[BIT_VOL]  = mode_w.vol;
        mode_word[BIT_SHDN] = mode_w.shdn;
        mode_word[BIT_WIP]  = busy_w;
        mode_word[BIT_SDO]  = mode_w.sdo_od;
    end

    // Read multiplexer with the busy lockout applied.
    always_comb begin
        rd_next = '0;
        if (sel_mode)
            rd_next = mode_word;
        else if (!busy_w) begin
            if (sel_shared)  rd_next = mode_w.vol ? wiper_reg_w : nv_rd;
            else if (sel_gp) rd_next = nv_rd;
        end
    end

    // Registered read data, updated only by accepted reads.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) rd_data <= '0;
        else if (rd_stb && ready) rd_data <= rd_next;
    end

    assign sdo_open_drain = mode_w.sdo_od;
endmodule

// File: rtl/pot_chk.sv
// Checker for potwiper_ctrl. Observes ports and the unit boundary signals.
// Bound to every instance of the top module.
module pot_chk #(
    parameter int NV_CYCLES = 1_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       pg_q,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       busy,
    input logic [7:0] wiper_reg,
    input logic [7:0] ivr_word,
    input logic [7:0] wiper_tap,
    input logic       pot_open
);
    int busy_run;

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R1
    pwrlow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (wiper_tap == 8'h80 && !pot_open && !busy));

    // R2
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !pg_q) |=> (wiper_reg == $past(ivr_word)));

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= NV_CYCLES);

    // R5
    read_keeps_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && pwr_good && pg_q) |=> $stable(wiper_reg));

    // R8
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && pwr_good) |=> $stable(wiper_reg));

    // R9
    shutdown_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pot_open) |-> (wiper_tap == 8'h00));

    // R9
    shutdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_open && $past(pot_open)) |-> $stable(wiper_tap));
endmodule

bind potwiper_ctrl pot_chk #(.NV_CYCLES(NV_CYCLES)) u_pot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .pg_q      (pg_q),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .busy      (busy_w),
    .wiper_reg (wiper_reg_w),
    .ivr_word  (nv_word0),
    .wiper_tap (wiper_tap),
    .pot_open  (pot_open)
);

// File: tb/test_potwiper_ctrl.sv
// Bench: a behavioural register-file model is stepped on each rising edge
// and compared with every output a quarter period later.
module test_potwiper_ctrl;
    localparam int NVC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] wiper_tap;
    logic       pot_open;
    logic       sdo_open_drain;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    int m_nv[15];
    int m_wiper, m_left, m_pidx, m_pdat, m_rd;
    bit m_vol, m_shdn, m_sdo, m_pgq;

    always #10 clk = ~clk;

    potwiper_ctrl #(.NV_CYCLES(NVC)) i_potwiper_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .wiper_tap(wiper_tap), .pot_open(pot_open),
        .sdo_open_drain(sdo_open_drain)
    );

    function automatic int model_read(int a, bit wip);
        if (a == 16) return (int'(m_vol) << 7) | (int'(m_shdn) << 6) | (int'(wip) << 5) | (int'(m_sdo) << 1);
        if (wip) return 0;
        if (a == 0) return m_vol ? m_wiper : m_nv[0];
        if (a >= 1 && a <= 14) return m_nv[a];
        return 0;
    endfunction

    task automatic compare();
        int exp_tap;
        exp_tap = m_shdn ? m_wiper : 0;
        n_cmp++;
        if (wiper_tap !== 8'(exp_tap) || pot_open !== !m_shdn ||
            sdo_open_drain !== m_sdo || rd_data !== 8'(m_rd)) begin
            n_bad++;
            $display("FAIL %s t=%0t tap/open/sdo/rd act %h/%b/%b/%h exp %h/%b/%b/%h",
                     phase, $time, wiper_tap, pot_open, sdo_open_drain, rd_data,
                     8'(exp_tap), !m_shdn, m_sdo, 8'(m_rd));
        end
    endtask

    // Reference model step and per-cycle comparison.
    always @(posedge clk) begin
        bit wip;
        if (!rst_n) begin
            foreach (m_nv[i]) m_nv[i] = 0;
            m_wiper = 'h80; m_vol = 0; m_shdn = 1; m_sdo = 0;
            m_pgq = 0; m_left = 0; m_rd = 0;
        end else if (!pwr_good) begin
            m_wiper = 'h80; m_vol = 0; m_shdn = 1; m_sdo = 0;
            m_pgq = 0; m_left = 0; m_rd = 0;
        end else begin
            wip = (m_left > 0);
            if (!m_pgq) m_wiper = m_nv[0];
            else begin
                if (rd_stb) m_rd = model_read(int'(reg_addr), wip);
                if (wr_stb && !wip) begin
                    if (reg_addr == 0) begin
                        m_wiper = int'(wr_data);
                        if (!m_vol) begin m_left = NVC; m_pidx = 0; m_pdat = int'(wr_data); end
                    end else if (reg_addr >= 1 && reg_addr <= 14) begin
                        m_left = NVC; m_pidx = int'(reg_addr); m_pdat = int'(wr_data);
                    end else if (reg_addr == 16) begin
                        m_vol = wr_data[7]; m_shdn = wr_data[6]; m_sdo = wr_data[1];
                    end
                end
            end
            if (wip) begin
                m_left--;
                if (m_left == 0) m_nv[m_pidx] = m_pdat;
            end
            m_pgq = 1;
        end
        #5 compare();
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_stb = 1'b1; reg_addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        rd_stb = 1'b1; reg_addr = 5'(a);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        phase = "R1"; idle(4); rst_n = 1'b1; idle(3);
        phase = "R2"; pwr_good = 1'b1; idle(2);
        phase = "R1"; rd(16); idle(1);

        phase = "R3"; wr(16, 'hC0); wr(0, 'h5A); rd(16); rd(0); idle(2);

        phase = "R4"; wr(16, 'h40); wr(0, 'h33); rd(16);
        phase = "R8"; wr(3, 'h11); rd(0); rd(3); wr(16, 'hFF); rd(16);
        phase = "R4"; idle(NVC); rd(16); rd(0);

        phase = "R5"; wr(16, 'hC0); wr(0, 'h77); wr(16, 'h40); rd(0); idle(2);

        phase = "R6";
        for (int i = 1; i <= 14; i++) begin wr(i, i * 17); idle(NVC + 1); end
        for (int i = 1; i <= 14; i++) rd(i);

        phase = "R10"; wr(15, 'hAA); rd(16); rd(15); wr(21, 'h55); rd(21); rd(16);

        phase = "R7"; wr(16, 'hFF); rd(16); wr(16, 'h3D); rd(16);

        phase = "R9"; wr(16, 'h80); idle(2); wr(0, 'h99); idle(2);
        wr(16, 'hC0); idle(2);

        phase = "R11"; rd(0); idle(3);

        phase = "R2"; pwr_good = 1'b0; idle(3); pwr_good = 1'b1; idle(2); rd(0);
        wr(0, 'h44); idle(3); pwr_good = 1'b0; idle(2); pwr_good = 1'b1; idle(2);
        rd(0); idle(2);

        finish_run();
    end
endmodule